// File: doc/BRIEF.md
# HDLC Bit-Stuffing Framer and Deframer

A bit-serial pair for flag-delimited frames. The transmit half takes payload bits one at a time through a valid/ready handshake. It wraps them between two flag octets (a zero, six ones, a zero) and adds a zero after any run of five payload ones. That added zero keeps the flag from ever appearing inside the payload. The receive half watches a serial line and locks onto flags. It removes the added zeros and delivers payload bits with a valid strobe, with pulses that mark the first bit of a frame, a clean frame close and an abort.

Both halves advance by one line bit on each cycle where `bit_en_i` is high, so one clock can serve any bit rate. Payload bytes are expected to be fed least significant bit first; serializing bytes is left to the producer. A frame begins when the producer raises valid while the transmitter is idle. It ends at the first bit time in the payload phase where valid is low, once any pending inserted zero has gone out.

The receiver holds back each destuffed bit for seven bit times. By the time a flag is recognized, none of the flag's own bits have been delivered as payload.

Top module: `hdlc_bitlink`

## Requirements
- R1: After reset the transmit line is 1, `tx_ready_o` is 0, and every receive output is 0.
- R2: While no frame is in progress and `tx_valid_i` is low, the transmit line stays 1. `tx_ready_o` is high only in the payload phase.
- R3: A frame on the line is the flag 0,1,1,1,1,1,1,0 (in line order, value 0x7E), then the stuffed payload, then the same flag. Flag bits are never stuffed.
- R4: After five consecutive payload ones, the transmitter sends a 0 and drops `tx_ready_o` for that bit time. The ones count restarts at frame start and after every 0, including the added 0.
- R5: A payload bit is taken on a `bit_en_i` cycle with `tx_valid_i` and `tx_ready_o` both high. Valid low at a payload bit time starts the closing flag, but a pending added 0 is sent first.
- R6: At the receiver, a 0 that follows exactly five ones is discarded.
- R7: At the receiver, six ones followed by a 0 is a flag. Payload bits come out as one-cycle `rx_valid_o` pulses, seven destuffed bits after they arrive, so no flag bit is ever delivered.
- R8: `rx_start_o` pulses together with the first payload bit delivered after a flag.
- R9: `rx_end_o` pulses when a flag arrives after at least one delivered bit. A flag with no delivered bits gives no pulse. One flag may both close a frame and open the next.
- R10: A seventh consecutive one, in a frame with delivered bits, pulses `rx_abort_o` with no `rx_end_o`. The receiver then ignores the line until the next flag. Seven ones before any delivered bit return the receiver to hunting with no pulse.
- R11: On cycles with `bit_en_i` low, the transmit line holds and no receive pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One line bit per high cycle, both halves |
| tx_valid_i | input | 1 | Payload bit available; low ends the frame |
| tx_data_i | input | 1 | Payload bit |
| tx_ready_o | output | 1 | Payload bit taken at this bit time |
| tx_line_o | output | 1 | Serial transmit line |
| rx_line_i | input | 1 | Serial receive line |
| rx_valid_o | output | 1 | Delivered payload bit strobe |
| rx_data_o | output | 1 | Delivered payload bit |
| rx_start_o | output | 1 | First payload bit of a frame |
| rx_end_o | output | 1 | Frame closed by a flag |
| rx_abort_o | output | 1 | Frame dropped on seven ones |

## Verification
The two functions that can land in the same bit time are zero insertion and frame closure. This happens when the payload ends in exactly five ones and the producer drops valid on the very bit time the added zero is owed. The bench provokes it with such a frame. It compares the captured transmit line against a stream it builds itself: the inserted zero must come before the closing flag. The loop-back receiver must deliver the exact payload followed by one frame-end pulse, with no abort.

// File: rtl/hdlc_bitlink_pkg.sv
package hdlc_bitlink_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_OPEN, TX_DATA, TX_CLOSE} tx_state_e;
  typedef enum logic {RX_HUNT, RX_OPEN} rx_state_e;
endpackage

// File: rtl/hdlc_bitlink_tx.sv
module hdlc_bitlink_tx import hdlc_bitlink_pkg::*; #(
  parameter int RunLen = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic valid_i,
  input  logic data_i,
  output logic ready_o,
  output logic line_o
);
  localparam int FlagLen = RunLen + 3;
  localparam int CntW    = $clog2(FlagLen);
  localparam int OnesW   = $clog2(RunLen + 1);
  localparam logic [CntW-1:0]  LastIdx = CntW'(FlagLen - 1);
  localparam logic [OnesW-1:0] RunMax  = OnesW'(RunLen);

  tx_state_e        state_q;
  logic [CntW-1:0]  cnt_q;
  logic [OnesW-1:0] ones_q;
  logic             stuff_now;

  // flag: zero, ones, zero
  function automatic logic flag_bit(input logic [CntW-1:0] idx);
    return (idx != '0) && (idx != LastIdx);
  endfunction

  assign stuff_now = (ones_q == RunMax);
  assign ready_o   = (state_q == TX_DATA) && !stuff_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      ones_q  <= '0;
      line_o  <= 1'b1;
    end else if (bit_en_i) begin
      case (state_q)
        TX_IDLE: begin
          if (valid_i) begin
            line_o  <= 1'b0;
            cnt_q   <= CntW'(1);
            state_q <= TX_OPEN;
          end else begin
            line_o <= 1'b1;
          end
        end
        TX_OPEN: begin
          line_o <= flag_bit(cnt_q);
          if (cnt_q == LastIdx) begin
            state_q <= TX_DATA;
            cnt_q   <= '0;
            ones_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        TX_DATA: begin
          if (stuff_now) begin
            line_o <= 1'b0;
            ones_q <= '0;
          end else if (valid_i) begin
            line_o <= data_i;
            ones_q <= data_i ? ones_q + 1'b1 : '0;
          end else begin
            line_o  <= 1'b0;
            cnt_q   <= CntW'(1);
            state_q <= TX_CLOSE;
          end
        end
        default: begin
          line_o <= flag_bit(cnt_q);
          if (cnt_q == LastIdx) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  AST_STUFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && state_q == TX_DATA && ones_q == RunMax) |=> !line_o); // R4
  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_DATA) |-> (ones_q <= RunMax)); // R4
  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && state_q == TX_IDLE && !valid_i) |=> line_o); // R2
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(line_o)); // R11
endmodule

// File: rtl/hdlc_bitlink_rx.sv
module hdlc_bitlink_rx import hdlc_bitlink_pkg::*; #(
  parameter int RunLen = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic line_i,
  output logic valid_o,
  output logic data_o,
  output logic start_o,
  output logic end_o,
  output logic abort_o
);
  localparam int FlagOnes = RunLen + 1;
  localparam int Hold     = RunLen + 2;
  localparam int OnesW    = $clog2(RunLen + 3);
  localparam int FillW    = $clog2(Hold + 1);
  localparam logic [OnesW-1:0] StuffRun = OnesW'(RunLen);
  localparam logic [OnesW-1:0] FlagRun  = OnesW'(FlagOnes);
  localparam logic [FillW-1:0] FillMax  = FillW'(Hold);

  rx_state_e        state_q;
  logic [OnesW-1:0] ones_q;
  logic [FillW-1:0] fill_q;
  logic [Hold-1:0]  hold_q;
  logic             started_q;
  logic             flag_hit, stuff_hit, abort_hit, saturated, push, emit;

  assign saturated = ones_q > FlagRun;
  assign flag_hit  = !line_i && (ones_q == FlagRun);
  assign stuff_hit = !line_i && (ones_q == StuffRun);
  assign abort_hit =  line_i && (ones_q == FlagRun);
  assign push = (state_q == RX_OPEN) && !flag_hit && !stuff_hit && !abort_hit
                && !(line_i && saturated);
  assign emit = push && (fill_q == FillMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_HUNT;
      ones_q    <= '0;
      fill_q    <= '0;
      hold_q    <= '0;
      started_q <= 1'b0;
      valid_o   <= 1'b0;
      data_o    <= 1'b0;
      start_o   <= 1'b0;
      end_o     <= 1'b0;
      abort_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      start_o <= 1'b0;
      end_o   <= 1'b0;
      abort_o <= 1'b0;
      if (bit_en_i) begin
        if (line_i) begin
          if (!saturated) ones_q <= ones_q + 1'b1;
        end else begin
          ones_q <= '0;
        end
        if (flag_hit) begin
          end_o     <= (state_q == RX_OPEN) && started_q;
          state_q   <= RX_OPEN;
          fill_q    <= '0;
          started_q <= 1'b0;
        end else if (abort_hit) begin
          abort_o   <= (state_q == RX_OPEN) && started_q;
          state_q   <= RX_HUNT;
          fill_q    <= '0;
          started_q <= 1'b0;
        end else if (push) begin
          hold_q <= {hold_q[Hold-2:0], line_i};
          if (emit) begin
            valid_o   <= 1'b1;
            data_o    <= hold_q[Hold-1];
            start_o   <= !started_q;
            started_q <= 1'b1;
          end else begin
            fill_q <= fill_q + 1'b1;
          end
        end
      end
    end
  end

  AST_START_HAS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> valid_o); // R8
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, end_o, abort_o})); // R9
  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FillMax); // R7
  AST_HUNT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_HUNT) |=> !valid_o); // R10
  AST_EVENTS_ON_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> (!valid_o && !end_o && !abort_o)); // R11
endmodule

// File: rtl/hdlc_bitlink.sv
module hdlc_bitlink #(
  parameter int RunLen = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic tx_valid_i,
  input  logic tx_data_i,
  output logic tx_ready_o,
  output logic tx_line_o,
  input  logic rx_line_i,
  output logic rx_valid_o,
  output logic rx_data_o,
  output logic rx_start_o,
  output logic rx_end_o,
  output logic rx_abort_o
);
  hdlc_bitlink_tx #(.RunLen(RunLen)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .valid_i  (tx_valid_i),
    .data_i   (tx_data_i),
    .ready_o  (tx_ready_o),
    .line_o   (tx_line_o)
  );

  hdlc_bitlink_rx #(.RunLen(RunLen)) i_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .line_i   (rx_line_i),
    .valid_o  (rx_valid_o),
    .data_o   (rx_data_o),
    .start_o  (rx_start_o),
    .end_o    (rx_end_o),
    .abort_o  (rx_abort_o)
  );
endmodule

// File: tb/test_hdlc_bitlink.sv
module test_hdlc_bitlink;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic tx_valid = 1'b0, tx_data = 1'b0;
  logic tx_ready, tx_line;
  logic raw_mode = 1'b0, raw_bit = 1'b1;
  logic rx_line;
  logic rx_valid, rx_data, rx_start, rx_end, rx_abort;

  int checks = 0, errors = 0;
  int div = 1;
  bit pause = 1'b0;
  bit en_fired = 1'b0;
  int ev_cnt = 0;
  bit line_log[$];

  typedef struct {int kind; bit val; bit first;} exp_t; // kind 0 bit, 1 end, 2 abort
  exp_t exp_q[$];

  always #2 clk = ~clk;
  assign rx_line = raw_mode ? raw_bit : tx_line;

  hdlc_bitlink i_hdlc_bitlink (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready), .tx_line_o(tx_line),
    .rx_line_i(rx_line), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_start_o(rx_start), .rx_end_o(rx_end), .rx_abort_o(rx_abort)
  );

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic void push_exp(input int k, input bit v, input bit f);
    exp_t e;
    e.kind = k; e.val = v; e.first = f;
    exp_q.push_back(e);
  endfunction

  // bit enable generator
  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      en_fired = bit_en;
      if (pause) bit_en <= 1'b0;
      else begin
        bit_en <= (c >= div - 1);
        c = (c >= div - 1) ? 0 : c + 1;
      end
    end
  end

  // line logger
  initial forever begin
    @(negedge clk);
    if (en_fired) line_log.push_back(tx_line);
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rx_valid || rx_end || rx_abort || rx_start) ev_cnt++;
    if (rx_start && !rx_valid) chk(0, "R8 start without bit act=1 exp=0");
    if (rx_valid || rx_end || rx_abort) begin
      int k;
      exp_t e;
      k = rx_valid ? 0 : (rx_end ? 1 : 2);
      if (exp_q.size() == 0) begin
        chk(0, $sformatf("R7/R9/R10 unexpected event act=%0d exp=none", k));
      end else begin
        e = exp_q.pop_front();
        if (k == 0)
          chk(e.kind == 0 && e.val == rx_data && e.first == rx_start,
              $sformatf("R7/R8 bit act=k%0d v%0d s%0d exp=k%0d v%0d s%0d",
                        k, rx_data, rx_start, e.kind, e.val, e.first));
        else
          chk(e.kind == k, $sformatf("R9/R10 event act=%0d exp=%0d", k, e.kind));
      end
    end
  end

  task automatic send_frame(input bit b[$], input int pause_at, input string tag);
    bit exp_line[$];
    int ones = 0, stuffs = 0, waits = 0, z, mism = 0, n;
    n = b.size();
    exp_line = '{0, 1, 1, 1, 1, 1, 1, 0};
    for (int i = 0; i < n; i++) begin
      push_exp(0, b[i], i == 0);
      exp_line.push_back(b[i]);
      ones = b[i] ? ones + 1 : 0;
      if (ones == 5) begin
        exp_line.push_back(1'b0);
        ones = 0;
        if (i < n - 1) stuffs++;
      end
    end
    if (n > 0) push_exp(1, 0, 0);
    exp_line.push_back(0);
    for (int i = 0; i < 6; i++) exp_line.push_back(1);
    exp_line.push_back(0);
    line_log.delete();
    for (int i = 0; i < n; i++) begin
      tx_valid = 1'b1;
      tx_data  = b[i];
      while (!(bit_en && tx_ready)) begin
        if (bit_en) waits++;
        @(negedge clk);
      end
      @(negedge clk);
      if (i == pause_at) begin
        bit snap;
        int ev0, moved = 0;
        pause = 1'b1;
        repeat (3) @(negedge clk);
        snap = tx_line;
        ev0 = ev_cnt;
        repeat (30) begin
          @(negedge clk);
          if (tx_line != snap) moved++;
        end
        chk(moved == 0, $sformatf("R11 line moved act=%0d exp=0", moved));
        chk(ev_cnt == ev0, $sformatf("R11 rx events act=%0d exp=%0d", ev_cnt, ev0));
        pause = 1'b0;
      end
    end
    tx_valid = 1'b0;
    repeat (40 * div) @(negedge clk);
    chk(waits == 8 + stuffs,
        $sformatf("R4/R5 %s ready-low bit times act=%0d exp=%0d", tag, waits, 8 + stuffs));
    z = -1;
    foreach (line_log[i]) if (z < 0 && line_log[i] == 0) z = i;
    if (z < 0 || z + exp_line.size() > line_log.size()) mism = 999;
    else foreach (exp_line[k]) if (line_log[z + k] != exp_line[k]) mism++;
    chk(mism == 0, $sformatf("R3/R4 %s line mismatches act=%0d exp=0", tag, mism));
    chk(exp_q.size() == 0, $sformatf("R7/R9 %s missing events act=%0d exp=0", tag, exp_q.size()));
  endtask

  task automatic send_raw(input bit q[$]);
    raw_mode = 1'b1;
    foreach (q[i]) begin
      while (!bit_en) @(negedge clk);
      raw_bit = q[i];
      @(negedge clk);
    end
    raw_bit = 1'b1;
  endtask

  initial begin
    bit f[$];
    int ev0;
    repeat (3) @(negedge clk);
    chk(tx_line == 1, $sformatf("R1 tx line act=%0d exp=1", tx_line));
    chk(tx_ready == 0, $sformatf("R1 ready act=%0d exp=0", tx_ready));
    chk({rx_valid, rx_start, rx_end, rx_abort} == 0,
        $sformatf("R1 rx outs act=%b exp=0000", {rx_valid, rx_start, rx_end, rx_abort}));
    rst_n = 1'b1;

    // R2 idle line
    ev0 = ev_cnt;
    begin
      int bad = 0;
      repeat (20) begin @(negedge clk); if (tx_line != 1 || tx_ready != 0) bad++; end
      chk(bad == 0, $sformatf("R2 idle line/ready bad act=%0d exp=0", bad));
    end
    chk(ev_cnt == ev0, $sformatf("R2 idle rx events act=%0d exp=%0d", ev_cnt, ev0));

    div = 1;
    f = '{1,0,1,1,0,0,1,0,0,1,1,1,0,1,0,0};
    send_frame(f, -1, "mixed R3 R5 R7 R8 R9");

    div = 3;
    f.delete();
    for (int i = 0; i < 20; i++) f.push_back(1);
    send_frame(f, 7, "ones R4 R6 R11");

    div = 2;
    f = '{1,0,1,1,1,1,1};
    send_frame(f, -1, "stuff-at-close R4 R5");

    div = 1;
    f = '{1,0,0,1,1,1,1,1,1,0,1};
    send_frame(f, -1, "flag-in-payload R4 R6");

    f = '{1};
    send_frame(f, -1, "single-bit R9");

    // R9 shared flag, empty frames
    f = '{0,1,1,1,1,1,1,0, 1,0,1, 0,1,1,1,1,1,1,0, 0,0,1,1, 0,1,1,1,1,1,1,0,
          0,1,1,1,1,1,1,0, 1,1,1,1,1,1,1,1};
    push_exp(0,1,1); push_exp(0,0,0); push_exp(0,1,0); push_exp(1,0,0);
    push_exp(0,0,1); push_exp(0,0,0); push_exp(0,1,0); push_exp(0,1,0); push_exp(1,0,0);
    send_raw(f);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, $sformatf("R9 shared flag missing act=%0d exp=0", exp_q.size()));

    // R10 abort, ignore garbage, recover
    f = '{0,1,1,1,1,1,1,0, 0,1,1,0,1,0,0,1,1,0, 1,1,1,1,1,1,1, 0,1,0,0,1,
          0,1,1,1,1,1,1,0, 0,0,1, 0,1,1,1,1,1,1,0, 1,1,1,1,1,1,1,1};
    push_exp(0,0,1); push_exp(0,1,0); push_exp(0,1,0); push_exp(0,0,0); push_exp(0,1,0);
    push_exp(0,0,0); push_exp(0,0,0); push_exp(0,1,0); push_exp(0,1,0); push_exp(2,0,0);
    push_exp(0,0,1); push_exp(0,0,0); push_exp(0,1,0); push_exp(1,0,0);
    send_raw(f);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, $sformatf("R10 abort sequence missing act=%0d exp=0", exp_q.size()));
    raw_mode = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule